// File: doc/BRIEF.md
# Stacked-Die SPI Die Selector

This block is the device-side command front end for a serial memory made of two dies stacked behind one SPI bus. It samples the bus (serial clock, active-low chip select, serial data in) into a system clock domain and assembles instruction bytes MSB first. It remembers which die is currently listening, and turns each instruction into a one-cycle command strobe for the die or dies that should act on it. The decoded opcode is presented alongside the strobe.

Only the listening die sees ordinary instructions. The idle die accepts only the die-select and reset opcodes. Each die owns a busy timer for an internal program or erase. That timer runs to completion no matter which die is selected, so a read can proceed on one die while the other programs, and both dies can program or erase at once.

Top module: `spi_stack_sel`

## Requirements
- R1: After rst_n is released, active_die is 0, die_busy is all zeros and no cmd_valid bit is high.
- R2: Bits are sampled on rising serial clock edges while spi_cs_n is low and are assembled MSB first. Only the first byte of a frame is an instruction: it gives one cmd_valid pulse with cmd_op equal to that byte, and later bytes of the frame give no pulse.
- R3: An instruction byte other than C2h and FFh pulses only cmd_valid[active_die].
- R4: A frame whose first byte is C2h (die select) gives no cmd_valid pulse. When spi_cs_n rises after exactly two complete bytes, active_die takes the value of the second byte, provided that value is below NUM_DIES.
- R5: A die-select frame with an ID of NUM_DIES or more, or with a byte count other than two, leaves active_die unchanged.
- R6: When spi_cs_n rises in the middle of a byte, the partial byte is discarded: it produces no strobe and does not count toward the byte total.
- R7: The reset opcode FFh pulses cmd_valid on every die, whichever die is active. One cycle later, die_busy of every die is 0.
- R8: An opcode of 10h (program) or D8h (erase) strobed to an idle-timer die raises that die's die_busy one cycle after the strobe. die_busy then stays high for exactly PROG_CYCLES or ERASE_CYCLES cycles respectively.
- R9: Die selection never aborts, pauses or restarts a busy timer. A die made idle while busy finishes on time, and both dies may be busy together.
- R10: A program or erase opcode strobed to a die that is already busy does not extend or restart its timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_di | input | 1 | SPI serial data into the device |
| cmd_valid | output | NUM_DIES | One-cycle command strobe per die |
| cmd_op | output | 8 | Opcode of the latest strobed instruction |
| active_die | output | DIE_W | Index of the die that listens |
| die_busy | output | NUM_DIES | Per-die program/erase in progress |

## Verification
The bench builds the block with NUM_DIES=2, SYNC_STAGES=2, PROG_CYCLES=300 and ERASE_CYCLES=700. These timer lengths are long enough that a two-byte die-select frame, and a further program frame to the other die, both fit inside a running erase. The concurrency and no-restart cases can therefore be measured with exact busy lengths. At the same time they are short enough for many frames to run. The vector table steps the selection through valid, out-of-range and wrong-length select frames. Between those it issues ordinary and reset opcodes and compares the per-die strobe counts.

// File: rtl/stack_sel_pkg.sv
package stack_sel_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_DIE_SEL     = 8'hC2;
    localparam logic [OP_W-1:0] OP_RESET       = 8'hFF;
    localparam logic [OP_W-1:0] OP_PROG_EXEC   = 8'h10;
    localparam logic [OP_W-1:0] OP_BLOCK_ERASE = 8'hD8;

    // frame byte tally saturates at three (three means "more than two")
    typedef logic [1:0] byte_tally_t;

    function automatic logic is_routed(input logic [OP_W-1:0] op);
        return (op != OP_DIE_SEL) && (op != OP_RESET);
    endfunction

endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_di,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_end
);

    localparam int BIT_CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [SYNC_STAGES-1:0] sclk_sync_q;
    logic [SYNC_STAGES-1:0] csn_sync_q;
    logic [SYNC_STAGES-1:0] di_sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_sync_q <= '0;
                    csn_sync_q  <= '1;
                    di_sync_q   <= '0;
                end else begin
                    sclk_sync_q <= spi_sclk;
                    csn_sync_q  <= spi_cs_n;
                    di_sync_q   <= spi_di;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_sync_q <= '0;
                    csn_sync_q  <= '1;
                    di_sync_q   <= '0;
                end else begin
                    sclk_sync_q <= {sclk_sync_q[SYNC_STAGES-2:0], spi_sclk};
                    csn_sync_q  <= {csn_sync_q[SYNC_STAGES-2:0], spi_cs_n};
                    di_sync_q   <= {di_sync_q[SYNC_STAGES-2:0], spi_di};
                end
            end
        end
    endgenerate

    logic sclk_s, csn_s, di_s;
    assign sclk_s = sclk_sync_q[SYNC_STAGES-1];
    assign csn_s  = csn_sync_q[SYNC_STAGES-1];
    assign di_s   = di_sync_q[SYNC_STAGES-1];

    typedef struct packed {
        logic                 sclk_prev;
        logic                 csn_prev;
        logic [BYTE_W-1:0]    shreg;
        logic [BIT_CNT_W-1:0] bit_cnt;
        logic                 stb;
        logic [BYTE_W-1:0]    data;
        logic                 fend;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        logic [BYTE_W-1:0] shifted;
        st_d           = st_q;
        st_d.stb       = 1'b0;
        st_d.fend      = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
        shifted        = {st_q.shreg[BYTE_W-2:0], di_s};
        if (csn_s) begin
            st_d.bit_cnt = '0;
            if (!st_q.csn_prev) begin
                st_d.fend = 1'b1;
            end
        end else if (sclk_s && !st_q.sclk_prev) begin
            st_d.shreg = shifted;
            if (st_q.bit_cnt == LAST_BIT) begin
                st_d.bit_cnt = '0;
                st_d.stb     = 1'b1;
                st_d.data    = shifted;
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sclk_prev: 1'b0, csn_prev: 1'b1, shreg: '0,
                      bit_cnt: '0, stb: 1'b0, data: '0, fend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_stb  = st_q.stb;
    assign byte_data = st_q.data;
    assign frame_end = st_q.fend;

endmodule

// File: rtl/stack_cmd_dec.sv
module stack_cmd_dec
    import stack_sel_pkg::*;
#(
    parameter int NUM_DIES = 2,
    parameter int DIE_W    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_stb,
    input  logic [OP_W-1:0]     byte_data,
    input  logic                frame_end,
    output logic [NUM_DIES-1:0] cmd_valid,
    output logic [OP_W-1:0]     cmd_op,
    output logic [DIE_W-1:0]    active_die
);

    localparam logic [NUM_DIES-1:0] ONE_HOT0 = NUM_DIES'(1);
    localparam logic [OP_W-1:0]     DIE_LIMIT = OP_W'(NUM_DIES);

    typedef struct packed {
        logic [DIE_W-1:0]    active;
        byte_tally_t         nbytes;
        logic [OP_W-1:0]     first_op;
        logic [OP_W-1:0]     die_id;
        logic [NUM_DIES-1:0] valid;
        logic [OP_W-1:0]     op;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = '0;
        if (byte_stb) begin
            if (st_q.nbytes == 2'd0) begin
                st_d.first_op = byte_data;
                if (byte_data == OP_RESET) begin
                    st_d.op    = byte_data;
                    st_d.valid = '1;
                end else if (is_routed(byte_data)) begin
                    st_d.op    = byte_data;
                    st_d.valid = ONE_HOT0 << st_q.active;
                end
            end else if (st_q.nbytes == 2'd1) begin
                st_d.die_id = byte_data;
            end
            if (st_q.nbytes != 2'd3) begin
                st_d.nbytes = st_q.nbytes + 2'd1;
            end
        end
        if (frame_end) begin
            if ((st_q.nbytes == 2'd2) && (st_q.first_op == OP_DIE_SEL)
                && (st_q.die_id < DIE_LIMIT)) begin
                st_d.active = st_q.die_id[DIE_W-1:0];
            end
            st_d.nbytes = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: '0, nbytes: '0, first_op: '0, die_id: '0,
                      valid: '0, op: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid  = st_q.valid;
    assign cmd_op     = st_q.op;
    assign active_die = st_q.active;

endmodule

// File: rtl/die_busy_timer.sv
module die_busy_timer #(
    parameter int PROG_CYCLES  = 3000,
    parameter int ERASE_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    input  logic abort,
    output logic busy
);

    localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d.remain = '0;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end else if (start_prog) begin
            st_d.remain = CNT_W'(PROG_CYCLES);
        end else if (start_erase) begin
            st_d.remain = CNT_W'(ERASE_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{remain: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.remain != '0);

endmodule

// File: rtl/spi_stack_sel.sv
module spi_stack_sel
    import stack_sel_pkg::*;
#(
    parameter int NUM_DIES     = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PROG_CYCLES  = 3000,
    parameter int ERASE_CYCLES = 20000,
    localparam int DIE_W       = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_di,
    output logic [NUM_DIES-1:0] cmd_valid,
    output logic [OP_W-1:0]     cmd_op,
    output logic [DIE_W-1:0]    active_die,
    output logic [NUM_DIES-1:0] die_busy
);

    logic            rx_byte_stb;
    logic [OP_W-1:0] rx_byte;
    logic            rx_frame_end;

    spi_byte_rx #(
        .SYNC_STAGES (SYNC_STAGES),
        .BYTE_W      (OP_W)
    ) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_di    (spi_di),
        .byte_stb  (rx_byte_stb),
        .byte_data (rx_byte),
        .frame_end (rx_frame_end)
    );

    stack_cmd_dec #(
        .NUM_DIES (NUM_DIES),
        .DIE_W    (DIE_W)
    ) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb   (rx_byte_stb),
        .byte_data  (rx_byte),
        .frame_end  (rx_frame_end),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .active_die (active_die)
    );

    generate
        for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
            logic go_prog, go_erase, go_abort;
            assign go_prog  = cmd_valid[g] && (cmd_op == OP_PROG_EXEC);
            assign go_erase = cmd_valid[g] && (cmd_op == OP_BLOCK_ERASE);
            assign go_abort = cmd_valid[g] && (cmd_op == OP_RESET);

            die_busy_timer #(
                .PROG_CYCLES  (PROG_CYCLES),
                .ERASE_CYCLES (ERASE_CYCLES)
            ) i_tmr (
                .clk         (clk),
                .rst_n       (rst_n),
                .start_prog  (go_prog),
                .start_erase (go_erase),
                .abort       (go_abort),
                .busy        (die_busy[g])
            );
        end
    endgenerate

endmodule

// File: rtl/stack_sel_chk.sv
module stack_sel_chk
    import stack_sel_pkg::*;
#(
    parameter int NUM_DIES = 2,
    parameter int DIE_W    = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_DIES-1:0] cmd_valid,
    input logic [OP_W-1:0]     cmd_op,
    input logic [DIE_W-1:0]    active_die,
    input logic [NUM_DIES-1:0] die_busy,
    input logic                rx_frame_end
);

    localparam logic [NUM_DIES-1:0] ONE_HOT0 = NUM_DIES'(1);

    AST_ROUTED_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0 && cmd_op != OP_RESET) |-> (cmd_valid == (ONE_HOT0 << active_die))); // R3

    AST_RESET_ALL_DIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0 && cmd_op == OP_RESET) |-> (cmd_valid == '1)); // R7

    AST_NO_SEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |-> (cmd_op != OP_DIE_SEL)); // R4

    AST_SEL_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_die) |-> $past(rx_frame_end)); // R4

    AST_ACTIVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(active_die) < NUM_DIES); // R5

    generate
        for (genvar g = 0; g < NUM_DIES; g++) begin : g_die_chk
            AST_BUSY_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(die_busy[g]) |-> ($past(cmd_valid[g]) &&
                    ($past(cmd_op) == OP_PROG_EXEC || $past(cmd_op) == OP_BLOCK_ERASE))); // R8

            AST_RESET_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid[g] && cmd_op == OP_RESET) |=> !die_busy[g]); // R7
        end
    endgenerate

endmodule

bind spi_stack_sel stack_sel_chk #(
    .NUM_DIES (NUM_DIES),
    .DIE_W    (DIE_W)
) i_stack_sel_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .active_die   (active_die),
    .die_busy     (die_busy),
    .rx_frame_end (rx_frame_end)
);

// File: tb/test_spi_stack_sel.sv
`timescale 1ns/1ps
module test_spi_stack_sel;

    localparam int NUM_DIES = 2;
    localparam int PROG_N   = 300;
    localparam int ERASE_N  = 700;
    localparam int HALF     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic di = 1'b0;
    logic [NUM_DIES-1:0] cmd_valid;
    logic [7:0]          cmd_op;
    logic [0:0]          active_die;
    logic [NUM_DIES-1:0] die_busy;

    always #4 clk = ~clk;

    spi_stack_sel #(
        .NUM_DIES     (NUM_DIES),
        .SYNC_STAGES  (2),
        .PROG_CYCLES  (PROG_N),
        .ERASE_CYCLES (ERASE_N)
    ) i_spi_stack_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_di     (di),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .active_die (active_die),
        .die_busy   (die_busy)
    );

    int checks = 0;
    int failures = 0;
    int stb_cnt [NUM_DIES];
    int run_len [NUM_DIES];
    int last_len [NUM_DIES];
    logic [7:0] last_op;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DIES; i++) begin
                stb_cnt[i]  <= 0;
                run_len[i]  <= 0;
                last_len[i] <= 0;
            end
            last_op <= 8'h00;
        end else begin
            for (int i = 0; i < NUM_DIES; i++) begin
                if (cmd_valid[i]) stb_cnt[i] <= stb_cnt[i] + 1;
                if (die_busy[i]) run_len[i] <= run_len[i] + 1;
                else if (run_len[i] != 0) begin
                    last_len[i] <= run_len[i];
                    run_len[i]  <= 0;
                end
            end
            if (cmd_valid != '0) last_op <= cmd_op;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            di = b[7-k];
            wait_clks(HALF);
            sclk = 1'b1;
            wait_clks(HALF);
            sclk = 1'b0;
        end
    endtask

    // n full bytes (third byte repeats b1), then optional partial bits
    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int n, input int part);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clks(HALF);
        if (n >= 1) send_bits(b0, 8);
        if (n >= 2) send_bits(b1, 8);
        if (n >= 3) send_bits(b1, 8);
        if (part > 0) send_bits((n == 0) ? b0 : b1, part);
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(20);
    endtask

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [1:0] nb;
        logic       act;
        logic [1:0] mask;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h03, 8'h00, 2'd1, 1'b0, 2'b01},
        '{8'hC2, 8'h01, 2'd2, 1'b1, 2'b00},
        '{8'h03, 8'h00, 2'd1, 1'b1, 2'b10},
        '{8'h9F, 8'h00, 2'd1, 1'b1, 2'b10},
        '{8'hC2, 8'h05, 2'd2, 1'b1, 2'b00},
        '{8'hFF, 8'h00, 2'd1, 1'b1, 2'b11},
        '{8'hC2, 8'h00, 2'd2, 1'b0, 2'b00},
        '{8'h0F, 8'hAA, 2'd2, 1'b0, 2'b01},
        '{8'hC2, 8'h01, 2'd1, 1'b0, 2'b00},
        '{8'hC2, 8'h01, 2'd3, 1'b0, 2'b00}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int c0, c1;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
        // R1 reset state
        check("R1 active_die", int'(active_die), 0);
        check("R1 die_busy", int'(die_busy), 0);
        check("R1 no strobes", stb_cnt[0] + stb_cnt[1], 0);

        // table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < 10; v++) begin
            c0 = stb_cnt[0];
            c1 = stb_cnt[1];
            frame(VECS[v].b0, VECS[v].b1, int'(VECS[v].nb), 0);
            check($sformatf("R4/R5 vec%0d active", v), int'(active_die), int'(VECS[v].act));
            check($sformatf("R3/R7 vec%0d die0 strobes", v), stb_cnt[0] - c0, int'(VECS[v].mask[0]));
            check($sformatf("R3/R7 vec%0d die1 strobes", v), stb_cnt[1] - c1, int'(VECS[v].mask[1]));
            if (VECS[v].mask != 2'b00)
                check($sformatf("R2 vec%0d opcode", v), int'(last_op), int'(VECS[v].b0));
        end

        // R6: select frame whose ID byte is cut after 4 bits
        frame(8'hC2, 8'h01, 1, 4);
        check("R6 cut id byte active", int'(active_die), 0);
        // R6: partial opcode alone gives no strobe
        c0 = stb_cnt[0];
        frame(8'h03, 8'h00, 0, 5);
        check("R6 partial opcode strobes", stb_cnt[0] - c0, 0);
        // R6: two bytes plus stray bits still counts as two bytes
        frame(8'hC2, 8'h01, 2, 3);
        check("R6 trailing partial select", int'(active_die), 1);
        frame(8'hC2, 8'h00, 2, 0);

        // R8/R9: erase on die0, move to die1 while busy, program die1
        frame(8'hD8, 8'h00, 1, 0);
        check("R8 die0 busy after erase", int'(die_busy[0]), 1);
        frame(8'hC2, 8'h01, 2, 0);
        check("R9 select while busy active", int'(active_die), 1);
        check("R9 die0 still busy", int'(die_busy[0]), 1);
        frame(8'h10, 8'h00, 1, 0);
        check("R9 both busy", int'(die_busy), 3);
        // R10: second program to busy die1
        frame(8'h10, 8'h00, 1, 0);
        wait_clks(ERASE_N + 50);
        check("R9 die0 erase length", last_len[0], ERASE_N);
        check("R8/R10 die1 program length", last_len[1], PROG_N);
        check("R8 both idle", int'(die_busy), 0);

        // R7: reset aborts busy on the idle die as well
        frame(8'hC2, 8'h00, 2, 0);
        frame(8'h10, 8'h00, 1, 0);
        frame(8'hC2, 8'h01, 2, 0);
        check("R9 die0 busy after deselect", int'(die_busy[0]), 1);
        frame(8'hFF, 8'h00, 1, 0);
        check("R7 reset clears busy", int'(die_busy), 0);
        check("R7 reset keeps selection", int'(active_die), 1);

        // R1: hardware reset returns to die 0
        @(negedge clk);
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        check("R1 active after re-reset", int'(active_die), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule